// File: doc/BRIEF.md
# Multi-Driver Strength Resolver

This combinational block settles the value of one shared net that several drivers can reach at once. Each driver offers a nine-valued logic value: uninitialized, forcing unknown, forcing 0, forcing 1, high impedance, weak unknown, weak 0, weak 1, or don't-care. The block combines these into one resolved value. Drive strength decides the result. A forcing value beats a weak one, a weak value beats high impedance, and a tie between opposite levels gives an unknown. That unknown is forcing or weak, matching the strength of the two values that disagree.

The combine rule for two values is applied across all driver slots in turn. Because the rule is symmetric and associative, the order of the slots does not change the result. The number of driver slots is a parameter, with a default of four. Unused slots are tied to high impedance.

Top module: `net_resolver`

## Requirements
- R1: If any driver carries U, the result is U.
- R2: If no driver carries U and at least one carries X, don't-care, or an unused code (9 to 15), the result is X.
- R3: A forcing 0 and a forcing 1 together, with no U or X-class value present, resolve to X.
- R4: A forcing value overrides any weak value or Z. A forcing 0 with L, H, W or Z gives 0, and a forcing 1 with any of these gives 1.
- R5: L together with H resolves to W. W combined with L, H, W or Z stays W, as long as no forcing value, U or X-class value is present.
- R6: Z is the identity. All drivers at Z resolve to Z. A single non-Z driver with the rest at Z passes through unchanged, except that don't-care and unused codes come out as X.
- R7: The result does not depend on which slot carries which value, so swapping two drivers never changes it.
- R8: The 4-bit encoding is U=0, X=1, 0=2, 1=3, Z=4, W=5, L=6, H=7, don't-care=8. The output is always one of the codes 0 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| drv_i | input | 4*NDRV | Driver values; slot k occupies bits 4k+3..4k |
| res_o | output | 4 | Resolved net value |

## Verification
The embedded assertions are evaluated whenever an input changes. They check four things: U dominance, the X outcome once any X-class value is present, the forcing-conflict X, and that all-Z inputs give Z and the output never leaves the legal output codes. Only the bench scenarios can show the rest. Those are the strength ordering between forcing, weak and Z values, the weak-conflict W, single-driver pass-through, and order independence. The bench covers them by sweeping every code pair through two slots in both orders and by comparing random driver sets against its own strength-ranked reference fold.

// File: rtl/net_resolver.sv
module net_resolver #(
  parameter int NDRV = 4
) (
  input  logic [4*NDRV-1:0] drv_i,
  output logic [3:0]        res_o
);
  localparam logic [3:0] V_U = 4'd0, V_X = 4'd1, V_0 = 4'd2, V_1 = 4'd3,
                         V_Z = 4'd4, V_W = 4'd5, V_L = 4'd6, V_H = 4'd7;

  function automatic logic [3:0] pair(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] p, q;
    p = (a > V_H) ? V_X : a;
    q = (b > V_H) ? V_X : b;
    if (p == V_U || q == V_U)      pair = V_U;
    else if (p == V_X || q == V_X) pair = V_X;
    else if (p == V_Z)             pair = q;
    else if (q == V_Z)             pair = p;
    else if ((p == V_0 || p == V_1) && (q == V_0 || q == V_1))
                                   pair = (p == q) ? p : V_X;
    else if (p == V_0 || p == V_1) pair = p;
    else if (q == V_0 || q == V_1) pair = q;
    else                           pair = (p == q) ? p : V_W;
  endfunction

  logic [3:0] acc;
  always_comb begin
    acc = V_Z;
    for (int k = 0; k < NDRV; k++) acc = pair(acc, drv_i[4*k +: 4]);
  end
  assign res_o = acc;

  logic any_u, any_x, any_0, any_1, all_z;
  always_comb begin
    any_u = 1'b0; any_x = 1'b0; any_0 = 1'b0; any_1 = 1'b0; all_z = 1'b1;
    for (int k = 0; k < NDRV; k++) begin
      if (drv_i[4*k +: 4] == V_U) any_u = 1'b1;
      if (drv_i[4*k +: 4] == V_X || drv_i[4*k +: 4] > V_H) any_x = 1'b1;
      if (drv_i[4*k +: 4] == V_0) any_0 = 1'b1;
      if (drv_i[4*k +: 4] == V_1) any_1 = 1'b1;
      if (drv_i[4*k +: 4] != V_Z) all_z = 1'b0;
    end
  end

  always_comb begin
    a_r1_u_dominates: assert (!any_u || res_o == V_U);
    a_r2_x_class: assert (any_u || !any_x || res_o == V_X);
    a_r3_force_clash: assert (any_u || any_x || !(any_0 && any_1) || res_o == V_X);
    a_r6_all_z: assert (!all_z || res_o == V_Z);
    a_r8_legal_out: assert (res_o <= V_H);
  end
endmodule

// File: tb/net_resolver_tb.sv
module net_resolver_tb_top;
  localparam int CLK_NS = 10;
  localparam int N = 4;
  localparam logic [3:0] CZ = 4'd4;

  logic clk = 1'b0;
  logic [4*N-1:0] drv;
  logic [3:0] res;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  net_resolver #(.NDRV(N)) dut_i (.drv_i(drv), .res_o(res));

  function automatic int strength(input logic [3:0] c);
    if (c == 4'd2 || c == 4'd3) return 2;
    if (c == 4'd4) return 0;
    return 1;
  endfunction

  function automatic logic [3:0] ref_pair(input logic [3:0] a, input logic [3:0] b);
    if (a == 4'd0 || b == 4'd0) return 4'd0;
    if (a == 4'd1 || a >= 4'd8 || b == 4'd1 || b >= 4'd8) return 4'd1;
    if (strength(a) > strength(b)) return a;
    if (strength(b) > strength(a)) return b;
    if (a == b) return a;
    return (strength(a) == 2) ? 4'd1 : 4'd5;
  endfunction

  function automatic string tag(input logic [3:0] a, input logic [3:0] b);
    if (a == 0 || b == 0) return "R1";
    if (a == 1 || a >= 8 || b == 1 || b >= 8) return "R2";
    if (a == 4 || b == 4) return "R6";
    if (strength(a) == 2 && strength(b) == 2) return "R3";
    if (strength(a) == 2 || strength(b) == 2) return "R4";
    return "R5";
  endfunction

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s drv=%h got=%0d exp=%0d", req, drv, got, exp);
    end
  endtask

  task automatic t_all_z;
    drv = {N{CZ}};
    #1 chk("R6", res, CZ);
  endtask

  task automatic t_single;
    for (int v = 0; v < 16; v++)
      for (int s = 0; s < N; s++) begin
        drv = {N{CZ}};
        drv[4*s +: 4] = 4'(v);
        #1 chk((v >= 8) ? "R8" : "R6", res, (v >= 8) ? 4'd1 : 4'(v));
      end
  endtask

  task automatic t_pairs;
    logic [3:0] fwd;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        drv = {N{CZ}};
        drv[3:0] = 4'(a); drv[4*N-1 -: 4] = 4'(b);
        #1 chk(tag(4'(a), 4'(b)), res, ref_pair(4'(a), 4'(b)));
        fwd = res;
        drv[3:0] = 4'(b); drv[4*N-1 -: 4] = 4'(a);
        #1 chk("R7", res, fwd);
      end
  endtask

  task automatic t_random;
    logic [3:0] acc, fwd;
    logic [4*N-1:0] v;
    for (int i = 0; i < 600; i++) begin
      for (int s = 0; s < N; s++)
        v[4*s +: 4] = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(8, 15))
                                                  : 4'($urandom_range(0, 7));
      if (i % 3 == 0) v[3:0] = CZ;
      acc = CZ;
      for (int s = 0; s < N; s++) acc = ref_pair(acc, v[4*s +: 4]);
      drv = v;
      #1 chk("R2", res, acc);
      fwd = res;
      for (int s = 0; s < N; s++) drv[4*s +: 4] = v[4*(N-1-s) +: 4];
      #1 chk("R7", res, fwd);
    end
  endtask

  initial begin
    drv = {N{CZ}};
    @(negedge clk);
    t_all_z();
    t_single();
    t_pairs();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule